// File: doc/BRIEF.md
# Logistic-Map Chaotic Stream Cipher

This block produces an 8-bit pseudo-random keystream by iterating the logistic map with a growth factor of four in unsigned fixed point. The state register holds x as a fraction with the binary point above bit 7. Each step forms the complement (1 − x) by inverting the state and adding one, then multiplies x by that complement in a single 8×8 multiplier. The factor of four comes from taking bits 13 down to 6 of the 16-bit product, so no shift stage is needed.

The current state is the keystream code. It is XORed with the data word, so encryption and decryption use the same path. When encrypting, a 4-bit plaintext is zero-extended and mixed into an 8-bit ciphertext. When decrypting, an 8-bit ciphertext is mixed and the low nibble is returned. A receiver loaded with the same seed, and stepped the same number of times, regenerates the same keystream and recovers the plaintext.

Seeds at the degenerate quarter points cannot be loaded; any such key is replaced by a fixed default. The block also guards against the state ever settling at zero.

Top module: `lmc_chaos_cipher`

## Requirements
- R1: After synchronous reset the state equals the default seed 0x5A and `seed_error` is low.
- R2: On a step, the next state is bits 13..6 of x·((~x + 1) mod 256), where x is the current 8-bit state. Arithmetically this is floor(x·(256 − x)/64) mod 256.
- R3: The state changes only on a clock edge with `step_en` or `seed_load` high. Otherwise the state holds its value.
- R4: A `seed_load` with a non-degenerate key puts that key into the state at the next edge. `seed_load` takes priority over `step_en` in the same cycle.
- R5: The degenerate keys 0x00, 0x40, 0x80 and 0xC0 (low six bits all zero) are not accepted. The state loads the default 0x5A instead, and `seed_error` is high for exactly the one cycle after that load edge.
- R6: The state is never 0x00. If a step's map result would be 0x00, the state reloads the last accepted seed instead.
- R7: With `dir_sel` = 0 (encrypt), `data_out` = state XOR {4'b0000, `data_in`[3:0]}, combinationally from the current state. `data_in`[7:4] is ignored.
- R8: With `dir_sel` = 1 (decrypt), `data_out` = {4'b0000, (state XOR `data_in`)[3:0]}.
- R9: Ciphertext produced from a seed and a step count decrypts to the original plaintext when the same seed and the same step count are used again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_key` into the state at the next edge |
| seed_key | input | 8 | Key value used as the initial fraction |
| step_en | input | 1 | Advance the map by one iteration at the next edge |
| dir_sel | input | 1 | 0 = encrypt, 1 = decrypt |
| data_in | input | 8 | Plaintext in the low nibble (encrypt) or ciphertext (decrypt) |
| data_out | output | 8 | Ciphertext (encrypt) or plaintext in the low nibble (decrypt) |
| seed_error | output | 1 | Pulses for one cycle after a degenerate key was replaced |

## Verification
The bench loads each of the four quarter-point keys. A design that accepted one of them would lock the keystream at a fixed point, and a design that stretched or missed the error pulse would flag the wrong cycle. It loads and steps in the same cycle, which catches a reversed priority. It also idles between steps, which catches a state that drifts without `step_en`. Long runs are compared step by step against an arithmetic model of the map, so a wrong product slice or a wrong complement offset shows up at the first step. Finally, encrypt-then-decrypt round trips with stray upper bits on `data_in` expose a mixer that fails to zero-extend the plaintext or fails to mask the recovered nibble.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    parameter int unsigned LMC_W        = 8;
    parameter int unsigned LMC_PW       = 4;
    parameter int unsigned LMC_PROD_W   = 2 * LMC_W;
    parameter int unsigned LMC_SLICE_HI = LMC_PROD_W - 3;
    parameter int unsigned LMC_SLICE_LO = LMC_W - 2;
    parameter int unsigned LMC_FRAC_LOW = LMC_W - 2;

    typedef logic [LMC_W-1:0]      lmc_word_t;
    typedef logic [LMC_PW-1:0]     lmc_plain_t;
    typedef logic [LMC_PROD_W-1:0] lmc_prod_t;

    typedef enum logic {
        LMC_ENCRYPT = 1'b0,
        LMC_DECRYPT = 1'b1
    } lmc_dir_e;

    typedef enum logic [1:0] {
        LMC_OP_HOLD = 2'd0,
        LMC_OP_LOAD = 2'd1,
        LMC_OP_STEP = 2'd2
    } lmc_op_e;

    typedef struct packed {
        lmc_word_t value;
        logic      rejected;
    } lmc_seed_t;

    typedef struct packed {
        lmc_word_t value;
        logic      is_zero;
    } lmc_next_t;

    // Quarter points (0, 1/4, 1/2, 3/4) have all bits below the top two clear.
    function automatic logic lmc_is_degenerate(input lmc_word_t x);
        return x[LMC_FRAC_LOW-1:0] == '0;
    endfunction

    // 1 - x in fixed point: bitwise inversion plus one.
    function automatic lmc_word_t lmc_complement(input lmc_word_t x);
        return ~x + lmc_word_t'(1);
    endfunction

endpackage

// File: rtl/lmc_map_step.sv
module lmc_map_step
    import lmc_pkg::*;
(
    input  lmc_word_t cur,
    output lmc_next_t nxt
);
    lmc_word_t comp;
    lmc_prod_t prod;

    always_comb begin
        comp          = lmc_complement(cur);
        prod          = lmc_prod_t'(cur) * lmc_prod_t'(comp);
        nxt.value     = prod[LMC_SLICE_HI:LMC_SLICE_LO];
        nxt.is_zero   = (prod[LMC_SLICE_HI:LMC_SLICE_LO] == '0);
    end
endmodule

// File: rtl/lmc_seed_guard.sv
module lmc_seed_guard
    import lmc_pkg::*;
#(
    parameter lmc_word_t FALLBACK = 8'h5A
) (
    input  lmc_word_t key,
    output lmc_seed_t res
);
    always_comb begin
        res.rejected = lmc_is_degenerate(key);
        res.value    = res.rejected ? FALLBACK : key;
    end
endmodule

// File: rtl/lmc_state_ctrl.sv
module lmc_state_ctrl
    import lmc_pkg::*;
#(
    parameter lmc_word_t FALLBACK = 8'h5A
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      step,
    input  lmc_seed_t seed,
    input  lmc_next_t nxt,
    output lmc_word_t state,
    output logic      seed_err
);
    lmc_op_e   op;
    lmc_word_t state_q;
    lmc_word_t anchor_q;
    logic      err_q;

    always_comb begin
        if (load)      op = LMC_OP_LOAD;
        else if (step) op = LMC_OP_STEP;
        else           op = LMC_OP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FALLBACK;
            anchor_q <= FALLBACK;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (op)
                LMC_OP_LOAD: begin
                    state_q  <= seed.value;
                    anchor_q <= seed.value;
                    err_q    <= seed.rejected;
                end
                LMC_OP_STEP: begin
                    state_q <= nxt.is_zero ? anchor_q : nxt.value;
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    assign state    = state_q;
    assign seed_err = err_q;
endmodule

// File: rtl/lmc_mixer.sv
module lmc_mixer
    import lmc_pkg::*;
(
    input  lmc_dir_e  dir,
    input  lmc_word_t code,
    input  lmc_word_t din,
    output lmc_word_t dout
);
    lmc_word_t mixed;

    always_comb begin
        if (dir == LMC_ENCRYPT) begin
            mixed = code ^ {{(LMC_W-LMC_PW){1'b0}}, din[LMC_PW-1:0]};
            dout  = mixed;
        end else begin
            mixed = code ^ din;
            dout  = {{(LMC_W-LMC_PW){1'b0}}, mixed[LMC_PW-1:0]};
        end
    end
endmodule

// File: rtl/lmc_chaos_cipher.sv
module lmc_chaos_cipher
    import lmc_pkg::*;
#(
    parameter logic [LMC_W-1:0] DEFAULT_SEED = 8'h5A
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_load,
    input  logic [LMC_W-1:0] seed_key,
    input  logic             step_en,
    input  logic             dir_sel,
    input  logic [LMC_W-1:0] data_in,
    output logic [LMC_W-1:0] data_out,
    output logic             seed_error
);
    lmc_seed_t seed_res;
    lmc_next_t map_nxt;
    lmc_word_t state_q;
    lmc_dir_e  dir;

    assign dir = lmc_dir_e'(dir_sel);

    lmc_seed_guard #(.FALLBACK(DEFAULT_SEED)) guard_i (
        .key (seed_key),
        .res (seed_res)
    );

    lmc_map_step map_i (
        .cur (state_q),
        .nxt (map_nxt)
    );

    lmc_state_ctrl #(.FALLBACK(DEFAULT_SEED)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .load     (seed_load),
        .step     (step_en),
        .seed     (seed_res),
        .nxt      (map_nxt),
        .state    (state_q),
        .seed_err (seed_error)
    );

    lmc_mixer mix_i (
        .dir  (dir),
        .code (state_q),
        .din  (data_in),
        .dout (data_out)
    );
endmodule

// File: rtl/lmc_chaos_cipher_chk.sv
module lmc_chaos_cipher_chk (
    input logic       clk,
    input logic       rst,
    input logic       seed_load,
    input logic [7:0] seed_key,
    input logic       step_en,
    input logic       dir_sel,
    input logic [7:0] data_out,
    input logic       seed_error,
    input logic [7:0] state_q
);
    function automatic logic [7:0] ref_map(input logic [7:0] x);
        int p;
        p = int'(x) * (256 - int'(x));
        return 8'((p >> 6) & 255);
    endfunction

    function automatic logic degen(input logic [7:0] k);
        return (k == 8'h00) || (k == 8'h40) || (k == 8'h80) || (k == 8'hC0);
    endfunction

    assert_map_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed_load && ref_map(state_q) != 8'h00) |=> state_q == ref_map($past(state_q)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !seed_load) |=> $stable(state_q));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        (seed_load && !degen(seed_key)) |=> state_q == $past(seed_key));

    assert_bad_seed_R5: assert property (@(posedge clk) disable iff (rst)
        (seed_load && degen(seed_key)) |=> (seed_error && state_q == 8'h5A));

    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !(seed_load && degen(seed_key)) |=> !seed_error);

    assert_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        state_q != 8'h00);

    assert_dec_nibble_R8: assert property (@(posedge clk) disable iff (rst)
        dir_sel |-> data_out[7:4] == 4'h0);
endmodule

bind lmc_chaos_cipher lmc_chaos_cipher_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .seed_load  (seed_load),
    .seed_key   (seed_key),
    .step_en    (step_en),
    .dir_sel    (dir_sel),
    .data_out   (data_out),
    .seed_error (seed_error),
    .state_q    (state_q)
);

// File: tb/lmc_chaos_cipher_tb_top.sv
module lmc_chaos_cipher_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       seed_load = 1'b0;
    logic [7:0] seed_key = 8'h00;
    logic       step_en = 1'b0;
    logic       dir_sel = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       seed_error;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmc_chaos_cipher dut_i (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_key(seed_key),
        .step_en(step_en), .dir_sel(dir_sel), .data_in(data_in),
        .data_out(data_out), .seed_error(seed_error)
    );

    function automatic logic [7:0] model_next(input logic [7:0] x);
        int p;
        p = int'(x) * (256 - int'(x));
        return 8'((p >> 6) & 255);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, then wait one full cycle.
    task automatic tick(input logic l, input logic [7:0] k, input logic s);
        seed_load = l; seed_key = k; step_en = s;
        @(negedge clk);
        seed_load = 1'b0; step_en = 1'b0;
    endtask

    // Keystream as seen at the port: encrypt a zero nibble.
    task automatic peek(output logic [7:0] code);
        dir_sel = 1'b0; data_in = 8'h00;
        #1;
        code = data_out;
    endtask

    task automatic t_reset();
        logic [7:0] c;
        rst = 1'b1;
        tick(1'b0, 8'h00, 1'b0);
        tick(1'b0, 8'h00, 1'b0);
        rst = 1'b0;
        peek(c);
        check("R1", "reset state", c, 8'h5A);
        check("R1", "reset seed_error", seed_error, 0);
    endtask

    task automatic t_step_sequence(input logic [7:0] seed, input int steps);
        logic [7:0] c, exp;
        int bad = 0;
        tick(1'b1, seed, 1'b0);
        exp = seed;
        for (int i = 0; i < steps; i++) begin
            tick(1'b0, 8'h00, 1'b1);
            exp = model_next(exp);
            if (exp == 8'h00) exp = seed;
            peek(c);
            if (c != exp) bad++;
            if (i < 3) check("R2", "map step", c, exp);
        end
        check("R2", "map sequence mismatches", bad, 0);
    endtask

    task automatic t_hold();
        logic [7:0] c0, c1;
        tick(1'b1, 8'h3B, 1'b0);
        peek(c0);
        for (int i = 0; i < 5; i++) tick(1'b0, 8'h00, 1'b0);
        peek(c1);
        check("R3", "hold without step", c1, c0);
        tick(1'b0, 8'h00, 1'b1);
        peek(c1);
        check("R3", "single step advances once", c1, model_next(8'h3B));
    endtask

    task automatic t_load_priority();
        logic [7:0] c;
        tick(1'b1, 8'h21, 1'b0);
        tick(1'b0, 8'h00, 1'b1);
        tick(1'b1, 8'h9D, 1'b1);
        peek(c);
        check("R4", "load wins over step", c, 8'h9D);
        check("R4", "no error on valid load", seed_error, 0);
    endtask

    task automatic t_degenerate(input logic [7:0] key);
        logic [7:0] c;
        tick(1'b1, 8'h11, 1'b0);
        tick(1'b1, key, 1'b0);
        peek(c);
        check("R5", "degenerate key replaced", c, 8'h5A);
        check("R5", "seed_error pulse", seed_error, 1);
        tick(1'b0, 8'h00, 1'b0);
        check("R5", "seed_error one cycle", seed_error, 0);
        tick(1'b0, 8'h00, 1'b1);
        peek(c);
        check("R5", "fallback steps normally", c, model_next(8'h5A));
    endtask

    task automatic t_nonzero_long(input logic [7:0] seed);
        logic [7:0] c;
        int zeros = 0;
        tick(1'b1, seed, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            tick(1'b0, 8'h00, 1'b1);
            peek(c);
            if (c == 8'h00) zeros++;
        end
        check("R6", "zero states seen", zeros, 0);
    endtask

    task automatic t_mixer();
        logic [7:0] code;
        tick(1'b1, 8'hA7, 1'b0);
        peek(code);
        for (int p = 0; p < 16; p += 5) begin
            dir_sel = 1'b0; data_in = 8'(p);
            #1;
            check("R7", "encrypt value", data_out, code ^ 8'(p));
            data_in = 8'(p) | 8'hF0;
            #1;
            check("R7", "upper nibble ignored", data_out, code ^ 8'(p));
        end
        dir_sel = 1'b1; data_in = 8'h3C;
        #1;
        check("R8", "decrypt value", data_out, {4'h0, (code[3:0] ^ 4'hC)});
        data_in = code ^ 8'h09;
        #1;
        check("R8", "decrypt recovers nibble", data_out, 8'h09);
        dir_sel = 1'b0;
    endtask

    task automatic t_roundtrip();
        logic [7:0] ct [8];
        logic [3:0] pt [8];
        int bad = 0;
        tick(1'b1, 8'h6B, 1'b0);
        dir_sel = 1'b0;
        for (int i = 0; i < 8; i++) begin
            pt[i] = 4'((i * 7 + 3) & 15);
            data_in = {4'hA, pt[i]};
            #1;
            ct[i] = data_out;
            tick(1'b0, 8'h00, 1'b1);
        end
        tick(1'b1, 8'h6B, 1'b0);
        dir_sel = 1'b1;
        for (int i = 0; i < 8; i++) begin
            data_in = ct[i];
            #1;
            if (data_out != {4'h0, pt[i]}) bad++;
            if (i == 0) check("R9", "first recovered nibble", data_out, {4'h0, pt[i]});
            tick(1'b0, 8'h00, 1'b1);
        end
        check("R9", "round trip mismatches", bad, 0);
        dir_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_step_sequence(8'h5A, 40);
        t_step_sequence(8'h01, 40);
        t_step_sequence(8'hFF, 40);
        t_hold();
        t_load_priority();
        t_degenerate(8'h00);
        t_degenerate(8'h40);
        t_degenerate(8'h80);
        t_degenerate(8'hC0);
        t_nonzero_long(8'h13);
        t_mixer();
        t_roundtrip();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule